// File: doc/BRIEF.md
# Command-Triggered Acquisition Bandwidth Sequencer

This block sits behind the command register of a receive modem. A microcontroller writes one byte at a time. Each write can start either of two fast-acquisition sequences, and it also hands a task code to the rest of the modem.

The first sequence controls the bit-timing loop. It starts the loop at its widest bandwidth and narrows it one step at a time. The second sequence controls the level and offset measurement. It starts that measurement at its quickest response and slows the response one step at a time. Each sequence stops when it reaches the normal setting held in a separate control register.

Any write with a trigger bit set restarts that sequence from its most aggressive step. A trigger is ignored in transmit mode. A trigger is also ignored when the same byte carries the reset task code. While a sequence is idle, its select output follows the normal setting.

Top module: `acq_sequencer`

## Requirements
- R1: In receive mode, a write with bit 7 = 1 and task field (bits 2:0) not 111 sets `bw_sel` to 0 and raises `bw_busy` on the next clock.
- R2: In receive mode, a write with bit 6 = 1 and task field not 111 sets `lev_sel` to 0 and raises `lev_busy` on the next clock.
- R3: A trigger write that arrives while a sequence is running restarts that sequence at code 0.
- R4: A write with a trigger bit at 0 leaves that sequence's select code and busy flag unchanged.
- R5: While `tx_mode` = 1, trigger bits start nothing.
- R6: A write whose task field is 111 (reset task) clears both busy flags and returns both selects to their normal settings, whatever the trigger bits hold.
- R7: While busy, a select code rises by one after every 4 `bit_tick` pulses until it equals the normal setting. The busy flag drops on the clock after that.
- R8: While a sequence is idle, its select output equals the current normal setting, one clock later.
- R9: Every write loads bits 2:0 into `task_code`. `task_go` pulses for one clock when that field is nonzero. Code 000 is the null task and gives no pulse.
- R10: Bits 5:3 of a written byte have no effect on any output.
- R11: While `rst_n` = 0 at a clock edge, both busy flags, `task_code` and `task_go` go to 0, and both selects take their normal settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Command register write strobe |
| wr_data | input | 8 | Command byte |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| bit_tick | input | 1 | One-cycle pulse per received bit |
| bw_normal | input | 2 | Normal loop bandwidth code (0 widest) |
| lev_normal | input | 2 | Normal level response code (0 fastest) |
| bw_sel | output | 2 | Current loop bandwidth code |
| lev_sel | output | 2 | Current level response code |
| bw_busy | output | 1 | Bit-clock acquisition in progress |
| lev_busy | output | 1 | Level acquisition in progress |
| task_code | output | 3 | Last written task field |
| task_go | output | 1 | One-clock pulse for a non-null task write |

## Verification
The assertions check the following on every clock:
- A valid trigger lands the sequence at code 0 with busy set.
- Transmit-mode triggers and reset-task writes leave the sequencers idle.
- A running select only holds or climbs by one.
- Idle selects track their normal settings.
- A non-null task write pulses `task_go`.

Some behaviour only the bench scenarios can show:
- The four-tick step length.
- The exact clock on which busy drops.
- Restarting a sequence part way through.
- Reserved bits having no effect.
- The two sequences running side by side with different targets.

// File: rtl/acq_pkg.sv
// Package: shared constants for the acquisition sequencer.
// Assumes an 8-bit command byte with fixed trigger and task field positions.
package acq_pkg;
    localparam int CMD_W       = 8;
    localparam int TASK_W      = 3;
    localparam int BIT_CLK_TRG = 7;
    localparam int BIT_LEV_TRG = 6;
    localparam logic [TASK_W-1:0] TASK_NULL  = 3'b000;
    localparam logic [TASK_W-1:0] TASK_RESET = 3'b111;
endpackage

// File: rtl/acq_cmd_decode.sv
// Module: acq_cmd_decode
// Turns a command register write into start and abort strobes for the two
// sequencers. It also registers the task field.
// Assumes that reserved bits 5:3 carry no meaning and are ignored.
module acq_cmd_decode
    import acq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CMD_W-1:0]  wr_data,
    input  logic              tx_mode,
    output logic              bw_start,
    output logic              lev_start,
    output logic              abort,
    output logic [TASK_W-1:0] task_code,
    output logic              task_go
);
    logic [TASK_W-1:0] task_field;
    logic              rx_ok;

    // Decode the write into start and abort strobes, with no register in between.
    always_comb begin
        task_field = wr_data[TASK_W-1:0];
        abort      = wr_en && (task_field == TASK_RESET);
        rx_ok      = wr_en && !tx_mode && !abort;
        bw_start   = rx_ok && wr_data[BIT_CLK_TRG];
        lev_start  = rx_ok && wr_data[BIT_LEV_TRG];
    end

    // Capture the task field and pulse task_go for a non-null task.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            task_code <= '0;
            task_go   <= 1'b0;
        end else begin
            task_go <= wr_en && (task_field != TASK_NULL);
            if (wr_en) begin
                task_code <= task_field;
            end
        end
    end
endmodule

// File: rtl/acq_stepper.sv
// Module: acq_stepper
// A single acquisition sequence. On start it jumps to code 0, the most
// aggressive setting. It then raises the code by one every TICKS_PER_STEP bit
// ticks until the code meets the normal setting. While idle, the code follows
// the normal setting.
// Assumes that start and abort are never high together (the decoder
// guarantees this).
module acq_stepper #(
    parameter int CODE_W         = 2,
    parameter int TICKS_PER_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              bit_tick,
    input  logic [CODE_W-1:0] normal,
    output logic [CODE_W-1:0] sel,
    output logic              busy
);
    localparam int CNT_W = (TICKS_PER_STEP > 1) ? $clog2(TICKS_PER_STEP) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_STEP - 1);

    logic [CNT_W-1:0] tick_cnt;

    // Run the step sequence: restart on start, finish at normal, otherwise follow normal.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            busy     <= 1'b0;
            sel      <= normal;
            tick_cnt <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            sel      <= '0;
            tick_cnt <= '0;
        end else if (busy) begin
            if (sel >= normal) begin
                busy <= 1'b0;
                sel  <= normal;
            end else if (bit_tick) begin
                if (tick_cnt == CNT_LAST) begin
                    tick_cnt <= '0;
                    sel      <= sel + CODE_W'(1);
                end else begin
                    tick_cnt <= tick_cnt + CNT_W'(1);
                end
            end
        end else begin
            sel      <= normal;
            tick_cnt <= '0;
        end
    end
endmodule

// File: rtl/acq_sequencer.sv
// Module: acq_sequencer (top)
// Command register front end with two independent acquisition sequencers:
// one for the bit-timing loop bandwidth and one for the level measurement
// response time.
// Assumes that bit_tick is a one-clock pulse in the clk domain.
module acq_sequencer
    import acq_pkg::*;
#(
    parameter int CODE_W         = 2,
    parameter int TICKS_PER_STEP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              tx_mode,
    input  logic              bit_tick,
    input  logic [CODE_W-1:0] bw_normal,
    input  logic [CODE_W-1:0] lev_normal,
    output logic [CODE_W-1:0] bw_sel,
    output logic [CODE_W-1:0] lev_sel,
    output logic              bw_busy,
    output logic              lev_busy,
    output logic [2:0]        task_code,
    output logic              task_go
);
    localparam int NSEQ = 2;

    logic              bw_start, lev_start, abort;
    logic [NSEQ-1:0]   starts, busys;
    logic [CODE_W-1:0] normals [NSEQ];
    logic [CODE_W-1:0] sels    [NSEQ];

    acq_cmd_decode u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .tx_mode   (tx_mode),
        .bw_start  (bw_start),
        .lev_start (lev_start),
        .abort     (abort),
        .task_code (task_code),
        .task_go   (task_go)
    );

    // Gather the per-sequence inputs into arrays for the generate loop.
    always_comb begin
        starts     = {lev_start, bw_start};
        normals[0] = bw_normal;
        normals[1] = lev_normal;
    end

    for (genvar g = 0; g < NSEQ; g++) begin : g_seq
        acq_stepper #(
            .CODE_W         (CODE_W),
            .TICKS_PER_STEP (TICKS_PER_STEP)
        ) u_step (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (starts[g]),
            .abort    (abort),
            .bit_tick (bit_tick),
            .normal   (normals[g]),
            .sel      (sels[g]),
            .busy     (busys[g])
        );
    end

    // Map the sequencer outputs onto the named ports.
    always_comb begin
        bw_sel   = sels[0];
        lev_sel  = sels[1];
        bw_busy  = busys[0];
        lev_busy = busys[1];
    end
endmodule

// File: rtl/acq_sequencer_chk.sv
// Module: acq_sequencer_chk
// Clocked properties over the top-level ports. It is bound to acq_sequencer.
// Assumes that no property is evaluated while rst_n is low.
module acq_sequencer_chk #(
    parameter int CODE_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [7:0]        wr_data,
    input logic              tx_mode,
    input logic [CODE_W-1:0] bw_normal,
    input logic [CODE_W-1:0] lev_normal,
    input logic [CODE_W-1:0] bw_sel,
    input logic [CODE_W-1:0] lev_sel,
    input logic              bw_busy,
    input logic              lev_busy,
    input logic              task_go
);
    AST_BW_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tx_mode && wr_data[7] && wr_data[2:0] != 3'b111) |=> (bw_busy && bw_sel == '0)); // R1
    AST_LEV_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tx_mode && wr_data[6] && wr_data[2:0] != 3'b111) |=> (lev_busy && lev_sel == '0)); // R2
    AST_BW_ZERO_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[7] && wr_data[2:0] != 3'b111 && bw_busy && bw_sel < bw_normal) |=> bw_busy); // R4
    AST_TX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_mode && !bw_busy && !lev_busy) |=> (!bw_busy && !lev_busy)); // R5
    AST_RESET_TASK: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[2:0] == 3'b111) |=> (!bw_busy && !lev_busy)); // R6
    AST_BW_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (bw_busy && !wr_en && bw_sel < bw_normal) |=>
        (bw_sel == $past(bw_sel) || bw_sel == $past(bw_sel) + CODE_W'(1))); // R7
    AST_LEV_MONOTONIC: assert property (@(posedge clk) disable iff (!rst_n)
        (lev_busy && !wr_en && lev_sel < lev_normal) |=>
        (lev_sel == $past(lev_sel) || lev_sel == $past(lev_sel) + CODE_W'(1))); // R7
    AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (!bw_busy && !wr_en) |=> (bw_sel == $past(bw_normal))); // R8
    AST_TASK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[2:0] != 3'b000) |=> task_go); // R9
endmodule

bind acq_sequencer acq_sequencer_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .tx_mode    (tx_mode),
    .bw_normal  (bw_normal),
    .lev_normal (lev_normal),
    .bw_sel     (bw_sel),
    .lev_sel    (lev_sel),
    .bw_busy    (bw_busy),
    .lev_busy   (lev_busy),
    .task_go    (task_go)
);

// File: tb/acq_sequencer_test.sv
module acq_sequencer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       tx_mode = 1'b0;
    logic       bit_tick = 1'b0;
    logic [1:0] bw_normal = 2'd2;
    logic [1:0] lev_normal = 2'd3;
    logic [1:0] bw_sel, lev_sel;
    logic       bw_busy, lev_busy, task_go;
    logic [2:0] task_code;
    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    acq_sequencer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tx_mode(tx_mode), .bit_tick(bit_tick), .bw_normal(bw_normal),
        .lev_normal(lev_normal), .bw_sel(bw_sel), .lev_sel(lev_sel),
        .bw_busy(bw_busy), .lev_busy(lev_busy), .task_code(task_code),
        .task_go(task_go)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One write cycle. It returns at the falling edge just after the write is taken.
    task automatic wr(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick = 1'b1;
            @(negedge clk); bit_tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R11 bw_busy", bw_busy, 0);
        chk("R11 lev_busy", lev_busy, 0);
        chk("R11 task_code", task_code, 0);
        chk("R11 task_go", task_go, 0);
        chk("R11 bw_sel", bw_sel, 2);
        chk("R11 lev_sel", lev_sel, 3);
        rst_n = 1'b1;
    endtask

    task automatic t_bw_run;
        wr(8'h80);
        chk("R1 bw_sel start", bw_sel, 0);
        chk("R1 bw_busy start", bw_busy, 1);
        chk("R2 lev untouched", lev_busy, 0);
        tick(3);
        chk("R7 bw_sel after 3 ticks", bw_sel, 0);
        tick(1);
        chk("R7 bw_sel after 4 ticks", bw_sel, 1);
        tick(4);
        chk("R7 bw_sel after 8 ticks", bw_sel, 2);
        chk("R7 busy still up", bw_busy, 1);
        @(negedge clk);
        chk("R7 busy drops", bw_busy, 0);
        tick(4);
        chk("R7 holds at normal", bw_sel, 2);
    endtask

    task automatic t_lev_run;
        wr(8'h40);
        chk("R2 lev_sel start", lev_sel, 0);
        chk("R2 lev_busy start", lev_busy, 1);
        chk("R1 bw untouched", bw_busy, 0);
        tick(12);
        chk("R7 lev_sel reaches 3", lev_sel, 3);
        @(negedge clk);
        chk("R7 lev_busy drops", lev_busy, 0);
    endtask

    task automatic t_restart_and_zero;
        wr(8'h80);
        tick(5);
        chk("R3 pre-restart sel", bw_sel, 1);
        wr(8'h00);
        chk("R4 zero write keeps sel", bw_sel, 1);
        chk("R4 zero write keeps busy", bw_busy, 1);
        wr(8'h38);
        chk("R10 reserved bits keep sel", bw_sel, 1);
        chk("R10 reserved bits keep busy", bw_busy, 1);
        chk("R10 task_code", task_code, 0);
        wr(8'h80);
        chk("R3 restart sel", bw_sel, 0);
        chk("R3 restart busy", bw_busy, 1);
        tick(4);
        chk("R3 restart counts afresh", bw_sel, 1);
        tick(4);
        @(negedge clk);
        chk("R3 run completes", bw_busy, 0);
    endtask

    task automatic t_tx;
        tx_mode = 1'b1;
        wr(8'hC0);
        chk("R5 tx bw_busy", bw_busy, 0);
        chk("R5 tx lev_busy", lev_busy, 0);
        chk("R5 tx bw_sel", bw_sel, 2);
        chk("R5 tx lev_sel", lev_sel, 3);
        tx_mode = 1'b0;
    endtask

    task automatic t_reset_task;
        wr(8'hC7);
        chk("R6 trig with reset bw", bw_busy, 0);
        chk("R6 trig with reset lev", lev_busy, 0);
        chk("R6 reset task_code", task_code, 7);
        wr(8'hC0);
        tick(2);
        chk("R6 both running", bw_busy + lev_busy, 2);
        wr(8'h07);
        chk("R6 abort bw_busy", bw_busy, 0);
        chk("R6 abort lev_busy", lev_busy, 0);
        chk("R6 abort bw_sel", bw_sel, 2);
        chk("R6 abort lev_sel", lev_sel, 3);
    endtask

    task automatic t_task_and_idle;
        wr(8'h05);
        chk("R9 task_code", task_code, 5);
        chk("R9 task_go pulse", task_go, 1);
        @(negedge clk);
        chk("R9 task_go one clock", task_go, 0);
        wr(8'h00);
        chk("R9 null no pulse", task_go, 0);
        chk("R9 null code", task_code, 0);
        wr(8'hBA);
        chk("R10 reserved with trigger sel", bw_sel, 0);
        chk("R10 reserved task_code", task_code, 2);
        tick(8);
        @(negedge clk);
        chk("R10 reserved run ends", bw_busy, 0);
        bw_normal = 2'd1;
        lev_normal = 2'd0;
        @(negedge clk);
        chk("R8 bw idle follows", bw_sel, 1);
        chk("R8 lev idle follows", lev_sel, 0);
    endtask

    initial begin
        t_reset;
        t_bw_run;
        t_lev_run;
        t_restart_and_zero;
        t_tx;
        t_reset_task;
        t_task_and_idle;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule